// File: doc/BRIEF.md
# Multi-Port Masked Word Memory

This block is a synthesizable storage model: a configurable number of words, each made of a regular data field plus a few spare columns. It offers several ports, and each port is typed at build time as one of three kinds. A read-write port reads or writes. A read-only port only reads. A write-only port only writes and has no data output.

Every port registers its request on the rising clock edge. This covers the select, the write enable, the address, the write data, the granule mask and the spare-column enables. On the next edge the registered request is applied to the shared array. All ports share one clock.

Partial writes are controlled per granule by the mask. Each spare column has its own enable, separate from the mask. The address is split into a column-select field in the low bits and a row field in the high bits. Together these fields pick one word of the array organised as rows of several words. When two ports write the same address in the same cycle, a fixed priority by port number settles the conflict.

Top module: `mp_sram`

## Requirements
- R1: Port kinds are set by 2-bit codes in `KINDS` (port p at bits 2p+1:2p): 0 = read-write, 1 = read-only, 2 = write-only. A read-write port reads when `csb_n` is low and `web_n` is high, and writes when both are low. A read-only port reads whenever `csb_n` is low and ignores `web_n`, `din`, `wmask` and `spare_we`. A write-only port writes when both are low, and its `dout` slice is always zero.
- R2: `csb_n` and `web_n` are active low. While a port's `csb_n` is high, the port neither reads nor writes, and its `dout` keeps its previous value.
- R3: A request is sampled at edge N. A write is visible to any read request sampled at edge N+1 or later. Read data appears on `dout` just after edge N+1.
- R4: With granule width G > 0, mask bit i enables data bits i*G up to min(i*G+G-1, DATA_W-1), so the last granule may be partial. The mask has ceil(DATA_W/G) bits. With G = 0 the mask is ignored and all data bits are written.
- R5: A word is DATA_W+SPARE bits wide. Data occupies bits DATA_W-1:0 and spare column k is bit DATA_W+k. Bit `spare_we[k]` alone enables the write of spare column k.
- R6: The low log2(WPR) address bits select the word within a row, and the remaining high bits select the row. Every address holds its own independent word.
- R7: When several ports write the same address in the same cycle, each bit enabled by more than one of them takes the value from the lowest-numbered port. A bit enabled by only one port takes that port's value.
- R8: A read of an address that is being written in the same cycle returns the word as it was before that write.
- R9: While `rst_n` is low, all `dout` slices are zero and no registered request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb_n | input | NP | Per-port select, active low |
| web_n | input | NP | Per-port write enable, active low |
| addr | input | NP*AW | Per-port address, port p at slice p*AW |
| din | input | NP*(DATA_W+SPARE) | Per-port write word |
| wmask | input | NP*MW | Per-port granule write mask |
| spare_we | input | NP*SW | Per-port spare-column write enables |
| dout | output | NP*(DATA_W+SPARE) | Per-port read word (zero for write-only ports) |

## Verification
Some properties are checked by the assertions on every cycle:
- an idle port never produces a registered request;
- no registered request is both a read and a write;
- a read-only port never registers a write;
- a write-only port's output stays zero;
- `dout` holds whenever the port was idle two edges earlier.

Data correctness can only be shown by the bench's scenarios. Its behavioural reference array checks:
- the granule and spare merging, including the partial last granule;
- the row/column address split;
- the lowest-port-wins collision rule;
- old data returned on a same-cycle read and write;
- write-to-read latency.

// File: rtl/mp_sram_pkg.sv
package mp_sram_pkg;
    typedef enum logic [1:0] {
        PK_RW = 2'd0,
        PK_RO = 2'd1,
        PK_WO = 2'd2
    } port_kind_e;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/mp_sram_capture.sv
module mp_sram_capture
    import mp_sram_pkg::*;
#(
    parameter logic [1:0] KIND = 2'd0,
    parameter int AW = 6,
    parameter int TW = 12,
    parameter int MW = 3,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csb_n,
    input  logic          web_n,
    input  logic [AW-1:0] addr,
    input  logic [TW-1:0] din,
    input  logic [MW-1:0] wmask,
    input  logic [SW-1:0] spare_we,
    output logic          q_rd,
    output logic          q_wr,
    output logic [AW-1:0] q_addr,
    output logic [TW-1:0] q_din,
    output logic [MW-1:0] q_mask,
    output logic [SW-1:0] q_spare
);
    localparam bit CAN_RD = (KIND != PK_WO);
    localparam bit CAN_WR = (KIND != PK_RO);
    localparam bit NEED_WEB = (KIND == PK_RW);

    logic want_rd, want_wr;

    always_comb begin
        want_rd = !csb_n && CAN_RD && (!NEED_WEB || web_n);
        want_wr = !csb_n && CAN_WR && !web_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_rd <= 1'b0;
            q_wr <= 1'b0;
        end else begin
            q_rd <= want_rd;
            q_wr <= want_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!csb_n) begin
            q_addr  <= addr;
            q_din   <= din;
            q_mask  <= wmask;
            q_spare <= spare_we;
        end
    end
endmodule

// File: rtl/mp_sram_bitsel.sv
module mp_sram_bitsel #(
    parameter int DATA_W = 10,
    parameter int GRAN_W = 4,
    parameter int SPARE  = 2,
    parameter int MW     = 3,
    parameter int SW     = 2
) (
    input  logic [MW-1:0]             mask,
    input  logic [SW-1:0]             spare,
    output logic [DATA_W+SPARE-1:0]   en
);
    genvar b, k;
    generate
        if (GRAN_W == 0) begin : g_whole
            assign en[DATA_W-1:0] = '1;
        end else begin : g_gran
            for (b = 0; b < DATA_W; b++) begin : g_bit
                assign en[b] = mask[b / GRAN_W];
            end
        end
        for (k = 0; k < SPARE; k++) begin : g_spare
            assign en[DATA_W+k] = spare[k];
        end
    endgenerate
endmodule

// File: rtl/mp_sram.sv
module mp_sram
    import mp_sram_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int DATA_W = 10,
    parameter int GRAN_W = 4,
    parameter int SPARE  = 2,
    parameter int WPR    = 4,
    parameter int NP     = 3,
    parameter logic [2*NP-1:0] KINDS = 6'b10_01_00,
    localparam int TW    = DATA_W + SPARE,
    localparam int AW    = $clog2(WORDS),
    localparam int MW    = (GRAN_W == 0) ? 1 : ceil_div(DATA_W, GRAN_W),
    localparam int SW    = (SPARE == 0) ? 1 : SPARE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP-1:0]   csb_n,
    input  logic [NP-1:0]   web_n,
    input  logic [NP*AW-1:0] addr,
    input  logic [NP*TW-1:0] din,
    input  logic [NP*MW-1:0] wmask,
    input  logic [NP*SW-1:0] spare_we,
    output logic [NP*TW-1:0] dout
);
    localparam int CW   = $clog2(WPR);
    localparam int ROWS = WORDS / WPR;

    logic [NP-1:0] cap_rd, cap_wr;
    logic [AW-1:0] cap_addr  [NP];
    logic [TW-1:0] cap_din   [NP];
    logic [TW-1:0] cap_en    [NP];
    logic [MW-1:0] cap_mask  [NP];
    logic [SW-1:0] cap_spare [NP];

    logic [TW-1:0] mem [ROWS][WPR];

    genvar p, r, c;
    generate
        for (p = 0; p < NP; p++) begin : g_port
            localparam logic [1:0] KP = KINDS[2*p +: 2];
            logic [TW-1:0] rd_q;

            mp_sram_capture #(.KIND(KP), .AW(AW), .TW(TW), .MW(MW), .SW(SW)) u_cap (
                .clk(clk), .rst_n(rst_n),
                .csb_n(csb_n[p]), .web_n(web_n[p]),
                .addr(addr[p*AW +: AW]), .din(din[p*TW +: TW]),
                .wmask(wmask[p*MW +: MW]), .spare_we(spare_we[p*SW +: SW]),
                .q_rd(cap_rd[p]), .q_wr(cap_wr[p]),
                .q_addr(cap_addr[p]), .q_din(cap_din[p]),
                .q_mask(cap_mask[p]), .q_spare(cap_spare[p])
            );

            mp_sram_bitsel #(.DATA_W(DATA_W), .GRAN_W(GRAN_W), .SPARE(SPARE),
                             .MW(MW), .SW(SW)) u_sel (
                .mask(cap_mask[p]), .spare(cap_spare[p]), .en(cap_en[p])
            );

            if (KP == PK_WO) begin : g_noread
                assign rd_q = '0;
            end else begin : g_read
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        rd_q <= '0;
                    end else if (cap_rd[p]) begin
                        rd_q <= mem[cap_addr[p][AW-1:CW]][cap_addr[p][CW-1:0]];
                    end
                end
            end
            assign dout[p*TW +: TW] = rd_q;
        end

        for (r = 0; r < ROWS; r++) begin : g_row
            for (c = 0; c < WPR; c++) begin : g_col
                localparam logic [AW-1:0] A = AW'(r * WPR + c);
                logic [TW-1:0] nxt;
                always_comb begin
                    nxt = mem[r][c];
                    for (int q = NP - 1; q >= 0; q--) begin
                        if (cap_wr[q] && cap_addr[q] == A) begin
                            nxt = (nxt & ~cap_en[q]) | (cap_din[q] & cap_en[q]);
                        end
                    end
                end
                always_ff @(posedge clk) begin
                    mem[r][c] <= nxt;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mp_sram_chk.sv
module mp_sram_chk
    import mp_sram_pkg::*;
#(
    parameter int NP = 3,
    parameter int TW = 12,
    parameter logic [2*NP-1:0] KINDS = 6'b10_01_00
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    csb_n,
    input logic [NP*TW-1:0] dout,
    input logic [NP-1:0]    cap_rd,
    input logic [NP-1:0]    cap_wr
);
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    genvar p;
    generate
        for (p = 0; p < NP; p++) begin : g_p
            localparam logic [1:0] KP = KINDS[2*p +: 2];

            AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || warm == 2'd0)
                $past(csb_n[p]) |-> !(cap_rd[p] || cap_wr[p])); // R2
            AST_CAPTURE_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({cap_rd[p], cap_wr[p]})); // R1
            AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || warm < 2'd2)
                $past(csb_n[p], 2) |-> $stable(dout[p*TW +: TW])); // R2

            if (KP == PK_RO) begin : g_ro
                AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                    !cap_wr[p]); // R1
            end
            if (KP == PK_WO) begin : g_wo
                AST_WO_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                    dout[p*TW +: TW] == '0); // R1
            end
        end
    endgenerate
endmodule

bind mp_sram mp_sram_chk #(.NP(NP), .TW(TW), .KINDS(KINDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .csb_n(csb_n), .dout(dout),
    .cap_rd(cap_rd), .cap_wr(cap_wr)
);

// File: tb/sim_mp_sram.sv
`timescale 1ns/1ps
module sim_mp_sram;
    localparam int NP = 3, DW = 10, G = 4, SP = 2, TW = 12, AW = 6, MW = 3, SW = 2;
    localparam int WORDS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    csb_n = '1, web_n = '1;
    logic [NP*AW-1:0] addr = '0;
    logic [NP*TW-1:0] din = '0;
    logic [NP*MW-1:0] wmask = '0;
    logic [NP*SW-1:0] spare_we = '0;
    logic [NP*TW-1:0] dout;

    always #4 clk = ~clk; // 125 MHz

    mp_sram u0 (.clk(clk), .rst_n(rst_n), .csb_n(csb_n), .web_n(web_n), .addr(addr),
                .din(din), .wmask(wmask), .spare_we(spare_we), .dout(dout));

    int total = 0, bad = 0, cyc = 0;
    string phase = "R9 reset";
    int kind [NP] = '{0, 1, 2};

    // behavioural reference
    logic [TW-1:0] rmem [WORDS];
    bit            p_rd [NP], p_wr [NP];
    int            p_a  [NP];
    logic [TW-1:0] p_d [NP], p_e [NP], expv [NP];

    function automatic logic [TW-1:0] en_of(input logic [MW-1:0] m, input logic [SW-1:0] s);
        logic [TW-1:0] e;
        for (int b = 0; b < DW; b++) e[b] = m[b / G];
        for (int k = 0; k < SP; k++) e[DW+k] = s[k];
        return e;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                p_rd[p] = 0; p_wr[p] = 0; expv[p] = '0;
            end
        end else begin
            for (int p = 0; p < NP; p++)
                if (p_rd[p]) expv[p] = rmem[p_a[p]];
            for (int p = NP - 1; p >= 0; p--)
                if (p_wr[p]) rmem[p_a[p]] = (rmem[p_a[p]] & ~p_e[p]) | (p_d[p] & p_e[p]);
            for (int p = 0; p < NP; p++) begin
                p_rd[p] = !csb_n[p] && (kind[p] == 1 || (kind[p] == 0 && web_n[p]));
                p_wr[p] = !csb_n[p] && kind[p] != 1 && !web_n[p];
                p_a[p]  = int'(addr[p*AW +: AW]);
                p_d[p]  = din[p*TW +: TW];
                p_e[p]  = en_of(wmask[p*MW +: MW], spare_we[p*SW +: SW]);
            end
        end
    end

    task automatic check(input bit ok, input int p, input logic [TW-1:0] act, input logic [TW-1:0] ex);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s port %0d: actual %h expected %h", phase, p, act, ex);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++)
                check(dout[p*TW +: TW] === expv[p], p, dout[p*TW +: TW], expv[p]);
        end
    end

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic idle_all;
        csb_n = '1; web_n = '1;
    endtask

    task automatic drive(input int p, input bit cs, input bit we, input int a,
                         input logic [TW-1:0] d, input logic [MW-1:0] m, input logic [SW-1:0] s);
        csb_n[p] = cs; web_n[p] = we;
        addr[p*AW +: AW] = AW'(a);
        din[p*TW +: TW] = d;
        wmask[p*MW +: MW] = m;
        spare_we[p*SW +: SW] = s;
    endtask

    initial begin
        for (int w = 0; w < WORDS; w++) rmem[w] = '0;
        idle_all();
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++)
            check(dout[p*TW +: TW] == '0, p, dout[p*TW +: TW], '0); // R9
        rst_n = 1'b1;

        phase = "R6 fill";
        for (int a = 0; a < WORDS / 2; a++) begin
            @(negedge clk);
            drive(0, 0, 0, 2*a,   TW'(a*37 ^ 12'h5A3), '1, '1);
            drive(1, 1, 1, 0, '0, '0, '0);
            drive(2, 0, 0, 2*a+1, TW'(a*91 ^ 12'hC3C), '1, '1);
        end

        phase = "R1 R6 readback";
        for (int a = 0; a < WORDS; a++) begin
            @(negedge clk);
            drive(0, 0, 1, a, '0, '0, '0);
            drive(1, 0, 0, WORDS-1-a, 12'hFFF, '1, '1);
            drive(2, 1, 0, a, '0, '0, '0);
        end

        phase = "R4 R5 random";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++)
                drive(p, ($urandom % 4) == 0, $urandom % 2, $urandom % WORDS,
                      TW'($urandom), MW'($urandom), SW'($urandom));
        end

        phase = "R7 R8 collide";
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            drive(0, ($urandom % 8) == 0, ($urandom % 4) == 0, $urandom % 4,
                  TW'($urandom), MW'($urandom), SW'($urandom));
            drive(1, 0, $urandom % 2, $urandom % 4, TW'($urandom), '1, '1);
            drive(2, ($urandom % 8) == 0, ($urandom % 4) == 0, $urandom % 4,
                  TW'($urandom), MW'($urandom), SW'($urandom));
        end

        phase = "R2 idle";
        @(negedge clk);
        drive(0, 1, 0, 7, 12'h123, '1, '1);
        drive(1, 1, 0, 7, 12'h456, '1, '1);
        drive(2, 1, 0, 7, 12'h789, '1, '1);
        repeat (5) @(negedge clk);

        phase = "R3 back-to-back";
        drive(0, 0, 0, 5, 12'hABC, 3'b101, 2'b01);
        @(negedge clk);
        drive(0, 1, 1, 0, '0, '0, '0);
        drive(1, 0, 1, 5, '0, '0, '0);
        @(negedge clk);
        drive(0, 0, 1, 5, '0, '0, '0);
        drive(1, 1, 1, 0, '0, '0, '0);
        drive(2, 0, 0, 5, 12'h3FF, 3'b111, 2'b11);
        @(negedge clk);
        idle_all();
        drive(1, 0, 1, 5, '0, '0, '0);
        @(negedge clk);
        idle_all();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule